// File: doc/BRIEF.md
# DDR3 Column and Mode Command Spacing Guard

This block sits between a DDR3 command scheduler and the PHY. Each controller clock the scheduler presents one candidate command (a code plus a target bank). The block answers with one "ok" flag per command class, all for the presented bank. Each flag is high only when every minimum spacing since the relevant earlier command has elapsed. When the scheduler actually sends the candidate it raises `cmd_issue`, and the guard starts the spacing windows that the command opens.

Each minimum is the larger of a fixed cycle count and a time in picoseconds. The time is converted to whole clock cycles at elaboration from the `TCK_PS` parameter, rounding up. The write-side windows are measured from the end of the write data burst, which is modelled as `CWL + 4` cycles after the WRITE command. Read-to-precharge, write-recovery and auto-precharge windows are kept per bank. Column-to-column, write-to-read and mode-register windows are global. If a command is sent while its flag is low, a sticky violation flag is set.

Top module: `ddr3_cmd_spacing_guard`

## Requirements
- R1: After a READ or WRITE is issued, `rd_ok` and `wr_ok` stay low until the column-to-column distance `CCD_CK` (default 4 cycles) has been reached.
- R2: After a READ to bank b, `pre_ok` for bank b stays low for max(4, ceil(7.5 ns / tCK)) cycles. Other banks are unaffected.
- R3: After a WRITE, `rd_ok` for every bank stays low until `CWL + 4 + max(4, ceil(7.5 ns / tCK))` cycles have passed.
- R4: After a WRITE to bank b, `pre_ok` for bank b stays low until `CWL + 4 + ceil(15 ns / tCK)` cycles have passed.
- R5: After a WRITE with `cmd_autopre` high to bank b, `rd_ok`, `wr_ok` and `pre_ok` for bank b stay low until `CWL + 4 + ceil(15 ns / tCK) + ceil(TRP_PS / tCK)` cycles have passed.
- R6: After a MODE REGISTER SET, `mrs_ok` stays low until distance `MRD_CK` (default 4).
- R7: After a MODE REGISTER SET, `rd_ok`, `wr_ok`, `pre_ok` and `oth_ok` stay low until distance max(12, ceil(15 ns / tCK)).
- R8: Issuing a command while its ok flag is low sets `violation` on the next cycle. `violation` then stays high until reset.
- R9: During and right after reset, all ok flags are high and `violation` is low.
- R10: Command codes are: 0 none, 1 READ, 2 WRITE, 3 PRECHARGE, 4 MODE REGISTER SET, and 5 to 7 other commands (checked against `oth_ok`). Issuing code 0 opens no window and never sets `violation`.

A distance of d means the second command is issued d clock edges after the first. In every rule above, the flag is high again at exactly the stated distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_issue | input | 1 | The presented command is sent this cycle |
| cmd_code | input | 3 | Presented command code (see R10) |
| cmd_bank | input | BANK_W | Target bank of the presented command |
| cmd_autopre | input | 1 | Presented WRITE carries auto-precharge |
| rd_ok | output | 1 | READ to `cmd_bank` is allowed |
| wr_ok | output | 1 | WRITE to `cmd_bank` is allowed |
| pre_ok | output | 1 | PRECHARGE to `cmd_bank` is allowed |
| mrs_ok | output | 1 | MODE REGISTER SET is allowed |
| oth_ok | output | 1 | Any other command is allowed |
| violation | output | 1 | Sticky flag: a command was sent while not allowed |

## Verification
The bench builds the guard with `TCK_PS = 1000`, `CWL = 5` and `TRP_PS = 13750`. With these values the nanosecond side wins for read-to-precharge (8), write-to-read (17 from the command) and mode-to-other (15). The cycle side still wins for column and mode-register spacing (4). All windows, the longest being the auto-precharge window of 38 cycles, are short enough for a full sweep. Every ordered pair of first and second command, with the second aimed at the same bank and at a different bank, is tried at every distance from 1 to 40. The expected flag is computed from the rule formulas, so each boundary is checked on both sides.

// File: rtl/ddr3_spacing_pkg.sv
package ddr3_spacing_pkg;

    localparam logic [2:0] CODE_NONE = 3'd0;
    localparam logic [2:0] CODE_RD   = 3'd1;
    localparam logic [2:0] CODE_WR   = 3'd2;
    localparam logic [2:0] CODE_PRE  = 3'd3;
    localparam logic [2:0] CODE_MRS  = 3'd4;

    // Round a picosecond interval up to whole clock cycles.
    function automatic int ps_to_ck(input int ps, input int tck_ps);
        return (ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spacing_ctr.sv
// Saturating down counter. A load keeps the larger of the new value and
// the value the counter would have reached anyway.
module spacing_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q, dec;

    always_comb begin
        dec   = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        cnt_d = (load_i && (val_i > dec)) ? val_i : dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R1
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q + 1'b1) == $past(cnt_q));
    // R1
    ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> cnt_q == '0);
    // R3
    ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q >= $past(val_i));
endmodule

// File: rtl/ddr3_bank_timer.sv
// Per-bank windows: precharge blocking (read-to-precharge, write recovery)
// and the whole-bank busy window after a write with auto-precharge.
module ddr3_bank_timer #(
    parameter int CW       = 6,
    parameter int RTP_LD   = 1,
    parameter int WRPRE_LD = 1,
    parameter int DAL_LD   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic ap_i,
    output logic pre_free_o,
    output logic bank_free_o
);
    logic          pre_load, dal_load;
    logic [CW-1:0] pre_val;

    always_comb begin
        pre_load = rd_hit_i || wr_hit_i;
        pre_val  = wr_hit_i ? CW'(WRPRE_LD) : CW'(RTP_LD);
        dal_load = wr_hit_i && ap_i;
    end

    spacing_ctr #(.CW(CW)) u_pre_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(pre_load), .val_i(pre_val),
        .zero_o(pre_free_o)
    );

    spacing_ctr #(.CW(CW)) u_dal_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(dal_load), .val_i(CW'(DAL_LD)),
        .zero_o(bank_free_o)
    );

    // R2
    rtp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && RTP_LD > 0) |=> !pre_free_o);
    // R4
    wrpre_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && WRPRE_LD > 0) |=> !pre_free_o);
    // R5
    dal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && ap_i && DAL_LD > 0) |=> !bank_free_o);
endmodule

// File: rtl/ddr3_cmd_spacing_guard.sv
module ddr3_cmd_spacing_guard
    import ddr3_spacing_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int TCK_PS     = 1250,
    parameter int CWL        = 8,
    parameter int BURST_CK   = 4,
    parameter int CCD_CK     = 4,
    parameter int RTP_MIN_CK = 4,
    parameter int RTP_PS     = 7500,
    parameter int WTR_MIN_CK = 4,
    parameter int WTR_PS     = 7500,
    parameter int WR_PS      = 15000,
    parameter int MRD_CK     = 4,
    parameter int MOD_MIN_CK = 12,
    parameter int MOD_PS     = 15000,
    parameter int TRP_PS     = 13750,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_issue,
    input  logic [2:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_autopre,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              pre_ok,
    output logic              mrs_ok,
    output logic              oth_ok,
    output logic              violation
);
    localparam int RTP_CK  = max_int(RTP_MIN_CK, ps_to_ck(RTP_PS, TCK_PS));
    localparam int WTR_CK  = max_int(WTR_MIN_CK, ps_to_ck(WTR_PS, TCK_PS));
    localparam int WR_CK   = ps_to_ck(WR_PS, TCK_PS);
    localparam int MOD_CK  = max_int(MOD_MIN_CK, ps_to_ck(MOD_PS, TCK_PS));
    localparam int RP_CK   = ps_to_ck(TRP_PS, TCK_PS);
    localparam int WEND_CK = CWL + BURST_CK;
    localparam int WR2RD   = WEND_CK + WTR_CK;
    localparam int WR2PRE  = WEND_CK + WR_CK;
    localparam int DAL_CK  = WR2PRE + RP_CK;
    localparam int CW      = $clog2(DAL_CK + 1);

    logic is_rd, is_wr, is_pre, is_mrs, is_oth;
    logic ccd_z, wtr_z, mrd_z, mod_z;
    logic [NUM_BANKS-1:0] pre_free, bank_free;
    logic cur_ok, viol_d, viol_q;

    always_comb begin
        is_rd  = cmd_issue && (cmd_code == CODE_RD);
        is_wr  = cmd_issue && (cmd_code == CODE_WR);
        is_pre = cmd_issue && (cmd_code == CODE_PRE);
        is_mrs = cmd_issue && (cmd_code == CODE_MRS);
        is_oth = cmd_issue && (cmd_code > CODE_MRS);
    end

    // Global windows
    spacing_ctr #(.CW(CW)) u_ccd_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(is_rd || is_wr),
        .val_i(CW'(CCD_CK - 1)), .zero_o(ccd_z)
    );
    spacing_ctr #(.CW(CW)) u_wtr_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(is_wr),
        .val_i(CW'(WR2RD - 1)), .zero_o(wtr_z)
    );
    spacing_ctr #(.CW(CW)) u_mrd_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(is_mrs),
        .val_i(CW'(MRD_CK - 1)), .zero_o(mrd_z)
    );
    spacing_ctr #(.CW(CW)) u_mod_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(is_mrs),
        .val_i(CW'(MOD_CK - 1)), .zero_o(mod_z)
    );

    // Per-bank windows
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank == BANK_W'(b));
        ddr3_bank_timer #(
            .CW(CW), .RTP_LD(RTP_CK - 1), .WRPRE_LD(WR2PRE - 1),
            .DAL_LD(DAL_CK - 1)
        ) u_timer (
            .clk(clk), .rst_n(rst_n),
            .rd_hit_i(is_rd && hit), .wr_hit_i(is_wr && hit),
            .ap_i(cmd_autopre),
            .pre_free_o(pre_free[b]), .bank_free_o(bank_free[b])
        );
    end

    always_comb begin
        rd_ok  = ccd_z && wtr_z && mod_z && bank_free[cmd_bank];
        wr_ok  = ccd_z && mod_z && bank_free[cmd_bank];
        pre_ok = mod_z && bank_free[cmd_bank] && pre_free[cmd_bank];
        mrs_ok = mrd_z;
        oth_ok = mod_z;
        cur_ok = !((is_rd && !rd_ok) || (is_wr && !wr_ok) || (is_pre && !pre_ok)
                   || (is_mrs && !mrs_ok) || (is_oth && !oth_ok));
        viol_d = viol_q || !cur_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_d;
    end

    assign violation = viol_q;

    // R8
    viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    // R8
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_code == CODE_RD && !rd_ok) |=> violation);
    // R1
    ccd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && (cmd_code == CODE_RD || cmd_code == CODE_WR) && CCD_CK > 1)
        |=> (!rd_ok && !wr_ok));
    // R6
    mrd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_code == CODE_MRS && MRD_CK > 1) |=> !mrs_ok);
    // R7
    mod_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_code == CODE_MRS && MOD_CK > 1) |=> (!oth_ok && !pre_ok));
    // R10
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_code == CODE_NONE && !violation) |=> !violation);
endmodule

// File: tb/test_ddr3_cmd_spacing_guard.sv
module test_ddr3_cmd_spacing_guard;
    localparam int TCK   = 1000;
    localparam int CWLV  = 5;
    localparam int TRP   = 13750;
    localparam int CCD   = 4;
    localparam int MRD   = 4;
    localparam int RTP   = ((7500 + TCK - 1) / TCK > 4) ? (7500 + TCK - 1) / TCK : 4;
    localparam int WTR   = RTP;
    localparam int WRC   = (15000 + TCK - 1) / TCK;
    localparam int MODC  = ((15000 + TCK - 1) / TCK > 12) ? (15000 + TCK - 1) / TCK : 12;
    localparam int RPC   = (TRP + TCK - 1) / TCK;
    localparam int WR2RD = CWLV + 4 + WTR;
    localparam int WR2PR = CWLV + 4 + WRC;
    localparam int DAL   = WR2PR + RPC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_issue = 1'b0, cmd_autopre = 1'b0;
    logic [2:0] cmd_code = 3'd0, cmd_bank = 3'd0;
    logic rd_ok, wr_ok, pre_ok, mrs_ok, oth_ok, violation;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    ddr3_cmd_spacing_guard #(.TCK_PS(TCK), .CWL(CWLV), .TRP_PS(TRP)) i_ddr3_cmd_spacing_guard (
        .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_autopre(cmd_autopre), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .pre_ok(pre_ok), .mrs_ok(mrs_ok), .oth_ok(oth_ok), .violation(violation)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_issue = 1'b0; cmd_code = 3'd0; cmd_bank = 3'd0; cmd_autopre = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic send(input int code, input int bank, input logic ap);
        cmd_issue = 1'b1; cmd_code = 3'(code); cmd_bank = 3'(bank); cmd_autopre = ap;
        @(negedge clk);
        cmd_issue = 1'b0; cmd_autopre = 1'b0; cmd_code = 3'd0;
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // first: 1 RD, 2 WR, 3 PRE, 4 MRS, 5 other, 6 WR with auto-precharge
    function automatic int need(input int a, input int b, input bit same);
        int n = 0;
        bit wra = (a == 2) || (a == 6);
        if ((a == 1 || wra) && (b == 1 || b == 2)) n = mx(n, CCD);
        if (wra && b == 1) n = mx(n, WR2RD);
        if (a == 1 && b == 3 && same) n = mx(n, RTP);
        if (wra && b == 3 && same) n = mx(n, WR2PR);
        if (a == 6 && same && b <= 3) n = mx(n, DAL);
        if (a == 4 && b == 4) n = mx(n, MRD);
        if (a == 4 && b != 4) n = mx(n, MODC);
        return n;
    endfunction

    function automatic string tag(input int a, input int b);
        if (a == 4) return (b == 4) ? "R6" : "R7";
        if (a == 6) return "R5";
        if (a == 2 && b == 1) return "R3";
        if (a == 2 && b == 3) return "R4";
        if (a == 1 && b == 3) return "R2";
        return "R1";
    endfunction

    function automatic logic okof(input int b);
        case (b)
            1: return rd_ok;
            2: return wr_ok;
            3: return pre_ok;
            4: return mrs_ok;
            default: return oth_ok;
        endcase
    endfunction

    initial begin
        #(4 * 190000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R9: reset state
        #1;
        check(rd_ok & wr_ok & pre_ok & mrs_ok & oth_ok, 1'b1, "R9", "ok flags in reset");
        check(violation, 1'b0, "R9", "violation in reset");
        do_reset();
        #1;
        for (int b = 1; b <= 5; b++) check(okof(b), 1'b1, "R9", "ok after reset");
        check(violation, 1'b0, "R9", "violation after reset");

        // Pairwise distance sweep (R1..R7)
        for (int a = 1; a <= 6; a++)
            for (int b = 1; b <= 5; b++)
                for (int bk = 0; bk <= 1; bk++)
                    for (int g = 1; g <= 40; g++) begin
                        do_reset();
                        send((a == 6) ? 2 : a, 0, a == 6);
                        repeat (g - 1) @(negedge clk);
                        cmd_code = 3'(b); cmd_bank = 3'(bk);
                        #1;
                        check(okof(b), (g >= need(a, b, bk == 0)) ? 1'b1 : 1'b0,
                              tag(a, b), $sformatf("first %0d second %0d bank %0d dist %0d", a, b, bk, g));
                    end

        // R8: too-close READs set violation, which then sticks
        do_reset();
        cmd_issue = 1'b1; cmd_code = 3'd1; cmd_bank = 3'd0;
        @(negedge clk);
        send(1, 0, 1'b0);
        #1 check(violation, 1'b1, "R8", "violation after early READ");
        repeat (50) @(negedge clk);
        #1 check(violation, 1'b1, "R8", "violation held");
        // R8: legal spacing leaves it clear
        do_reset();
        send(1, 0, 1'b0);
        repeat (CCD - 1) @(negedge clk);
        send(1, 0, 1'b0);
        #1 check(violation, 1'b0, "R8", "no violation at legal distance");

        // R10: code 0 opens nothing; codes 5..7 are other commands
        do_reset();
        repeat (5) send(0, 0, 1'b0);
        #1;
        check(rd_ok & wr_ok & pre_ok & mrs_ok & oth_ok, 1'b1, "R10", "ok after code 0");
        check(violation, 1'b0, "R10", "violation after code 0");
        do_reset();
        send(4, 0, 1'b0);
        send(0, 0, 1'b0);
        #1 check(violation, 1'b0, "R10", "code 0 inside mode window");
        send(7, 0, 1'b0);
        #1 check(violation, 1'b1, "R10", "code 7 inside mode window");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule